// File: doc/BRIEF.md
# Sponge Hash Engine with Iterated Round Permutation

This block computes an 80-bit digest of a message of up to `MSG_W` bits with a sponge construction. It holds a 100-bit state organised as a 5x5 grid of 4-bit cells. One combinational round datapath is reused for every permutation, one round per clock, twelve rounds per call. A single controller sequences the whole operation. It pads the message and absorbs one 20-bit block per permutation call. It then takes five 16-bit squeeze lanes and collects them in a merge shift register that drives the digest output.

The host places the message on `msg_i` and its bit length on `len_i`, then pulses `start_i` for one cycle. The block copies the message and length into internal registers when it accepts the start, so the host may change `msg_i` and `len_i` afterwards. When the last lane is captured, `done_o` pulses for one cycle. The digest then stays on `digest_o` until the next start is accepted.

Top module: `photon_sponge_hash`

## Requirements
- R1: After synchronous reset, or a reset applied in the middle of a run, `done_o` is 0 and `digest_o` is all zeros.
- R2: The message bits are taken from the top of `msg_i`: bit `MSG_W-1` is the first bit, and `len_i` counts the valid bits (0 to `MSG_W`). Padding appends one 1 bit and then zeros up to the next multiple of 20 bits, giving floor(len/20)+1 blocks. Bits of `msg_i` beyond the length have no effect on the digest.
- R3: State cell (row r, column c) occupies bits [99-4(5r+c) -: 4]. On a start, every cell is cleared except the low 24 bits, which are loaded with 0x141410.
- R4: Each padded block is XORed into state bits [99:80] (row 0), with the block's first bit at bit 99. A permutation call follows each block.
- R5: A permutation is 12 rounds. In round k (k = 0 to 11), cell (r,0) is XORed with RC_k ^ IC_r, where RC = 1,3,7,14,13,11,6,12,9,2,5,10 and IC = 0,1,3,6,4.
- R6: Every cell then passes through the 4-bit S-box C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 (the entry for inputs 0 to F, in that order).
- R7: Row r is then rotated left by r cells: new(r,c) = old(r,(c+r) mod 5).
- R8: Each column (row 0 first) is then transformed five times by the step (a0..a4) -> (a1,a2,a3,a4, 1·a0 ^ 2·a1 ^ 9·a2 ^ 9·a3 ^ 2·a4), multiplying over GF(16) with the polynomial x^4+x+1.
- R9: A squeeze lane is state bits [99:84]. The first lane is taken right after the last absorb permutation. Each of the four later lanes is taken after one more permutation. The first lane ends up in `digest_o[79:64]` and the last in `digest_o[15:0]`.
- R10: `done_o` goes high for exactly one cycle, 13·(floor(len/20)+1)+53 clock edges after the edge that samples the accepted start.
- R11: A start arriving while a run is in progress is ignored, together with any change of `msg_i` or `len_i` during the run. `digest_o` stays constant from `done_o` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to hash; honoured only when idle |
| msg_i | input | MSG_W | Message, first bit at the MSB |
| len_i | input | $clog2(MSG_W+1) | Message length in bits |
| digest_o | output | 80 | Collected squeeze lanes |
| done_o | output | 1 | One-cycle pulse when the digest is complete |

## Verification
The case hardest to reach from the ports is padding at block edges. When the length is an exact multiple of 20, the final block holds only the marker bit. Just below such a length, the marker lands in the last bit of a block. The stimulus sweeps every length from 0 to `MSG_W` with changing content, so every marker position and block count is hit. A second start with a different message and length is injected in the middle of a run, to show that the first request's result and timing are kept.

// File: rtl/photon_pkg.sv
package photon_pkg;
  localparam int CELL_W   = 4;
  localparam int DIM      = 5;
  localparam int NCELL    = DIM * DIM;
  localparam int STATE_W  = CELL_W * NCELL;
  localparam int RATE     = 20;
  localparam int SQZ_W    = 16;
  localparam int DIGEST_W = 80;
  localparam int N_LANES  = DIGEST_W / SQZ_W;
  localparam int ROUNDS   = 12;
  localparam int RND_W    = $clog2(ROUNDS);
  localparam int TAIL_W   = 24;
  localparam logic [TAIL_W-1:0] IV_TAIL = {8'(DIGEST_W / 4), 8'(RATE), 8'(SQZ_W)};

  typedef logic [CELL_W-1:0] cell_t;
  typedef enum logic [1:0] {PH_IDLE, PH_ABSORB, PH_PERM, PH_SQZ} phase_t;

  function automatic cell_t sbox(input cell_t x);
    case (x)
      4'h0: sbox = 4'hC;  4'h1: sbox = 4'h5;  4'h2: sbox = 4'h6;  4'h3: sbox = 4'hB;
      4'h4: sbox = 4'h9;  4'h5: sbox = 4'h0;  4'h6: sbox = 4'hA;  4'h7: sbox = 4'hD;
      4'h8: sbox = 4'h3;  4'h9: sbox = 4'hE;  4'hA: sbox = 4'hF;  4'hB: sbox = 4'h8;
      4'hC: sbox = 4'h4;  4'hD: sbox = 4'h7;  4'hE: sbox = 4'h1;  default: sbox = 4'h2;
    endcase
  endfunction

  function automatic cell_t round_const(input logic [RND_W-1:0] k);
    case (k)
      4'd0: round_const = 4'd1;   4'd1: round_const = 4'd3;   4'd2: round_const = 4'd7;
      4'd3: round_const = 4'd14;  4'd4: round_const = 4'd13;  4'd5: round_const = 4'd11;
      4'd6: round_const = 4'd6;   4'd7: round_const = 4'd12;  4'd8: round_const = 4'd9;
      4'd9: round_const = 4'd2;   4'd10: round_const = 4'd5;  4'd11: round_const = 4'd10;
      default: round_const = 4'd0;
    endcase
  endfunction

  function automatic cell_t row_const(input int r);
    case (r)
      1: row_const = 4'd1;
      2: row_const = 4'd3;
      3: row_const = 4'd6;
      4: row_const = 4'd4;
      default: row_const = 4'd0;
    endcase
  endfunction

  function automatic cell_t mix_coef(input int i);
    case (i)
      0: mix_coef = 4'd1;
      1: mix_coef = 4'd2;
      2: mix_coef = 4'd9;
      3: mix_coef = 4'd9;
      default: mix_coef = 4'd2;
    endcase
  endfunction

  function automatic cell_t gf_xtime(input cell_t x);
    gf_xtime = {x[2:0], 1'b0} ^ (x[3] ? 4'h3 : 4'h0);
  endfunction

  function automatic cell_t gf_mul(input cell_t a, input cell_t b);
    cell_t acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < CELL_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    gf_mul = acc;
  endfunction

  function automatic logic [CELL_W*DIM-1:0] mix_col(input logic [CELL_W*DIM-1:0] col);
    logic [CELL_W*DIM-1:0] v;
    cell_t t;
    v = col;
    for (int it = 0; it < DIM; it++) begin
      t = '0;
      for (int i = 0; i < DIM; i++)
        t = t ^ gf_mul(mix_coef(i), v[CELL_W*DIM-1-CELL_W*i -: CELL_W]);
      v = {v[CELL_W*(DIM-1)-1:0], t};
    end
    mix_col = v;
  endfunction
endpackage

// File: rtl/photon_pad.sv
module photon_pad
  import photon_pkg::*;
#(
  parameter int MSG_W = 128,
  parameter int LEN_W = 8,
  parameter int BLK_W = 3
) (
  input  logic [MSG_W-1:0] msg_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic [RATE-1:0]  blk_o
);
  function automatic logic pad_bit(input logic [MSG_W-1:0] m, input int len, input int p);
    if (p < len) pad_bit = m[MSG_W-1-p];
    else         pad_bit = (p == len);
  endfunction

  for (genvar j = 0; j < RATE; j++) begin : g_bit
    assign blk_o[RATE-1-j] = pad_bit(msg_i, int'(len_i), int'(blk_i) * RATE + j);
  end
endmodule

// File: rtl/photon_round.sv
module photon_round
  import photon_pkg::*;
(
  input  logic [STATE_W-1:0] st_i,
  input  logic [RND_W-1:0]   rnd_i,
  output logic [STATE_W-1:0] st_o
);
  cell_t cin  [NCELL];
  cell_t cadd [NCELL];
  cell_t csub [NCELL];
  cell_t cshf [NCELL];
  logic [CELL_W*DIM-1:0] colv [DIM];
  logic [CELL_W*DIM-1:0] mcol [DIM];
  cell_t rc;

  assign rc = round_const(rnd_i);

  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      localparam int K = r * DIM + c;
      assign cin[K] = st_i[STATE_W-1-CELL_W*K -: CELL_W];
      if (c == 0) begin : g_add
        assign cadd[K] = cin[K] ^ rc ^ row_const(r);
      end else begin : g_pass
        assign cadd[K] = cin[K];
      end
      assign csub[K] = sbox(cadd[K]);
      assign cshf[K] = csub[r * DIM + ((c + r) % DIM)];
      assign colv[c][CELL_W*DIM-1-CELL_W*r -: CELL_W] = cshf[K];
      assign st_o[STATE_W-1-CELL_W*K -: CELL_W] = mcol[c][CELL_W*DIM-1-CELL_W*r -: CELL_W];
    end
  end

  for (genvar c = 0; c < DIM; c++) begin : g_mix
    assign mcol[c] = mix_col(colv[c]);
  end
endmodule

// File: rtl/photon_merge.sv
module photon_merge #(
  parameter int LANE_W  = 16,
  parameter int N_LANES = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr_i,
  input  logic                      shift_i,
  input  logic [LANE_W-1:0]         lane_i,
  output logic [LANE_W*N_LANES-1:0] dout_o
);
  localparam int OUT_W = LANE_W * N_LANES;

  always_ff @(posedge clk) begin
    if (rst || clr_i) dout_o <= '0;
    else if (shift_i) dout_o <= {dout_o[OUT_W-LANE_W-1:0], lane_i};
  end

  // R11
  merge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !shift_i) |=> $stable(dout_o));
endmodule

// File: rtl/photon_sponge_hash.sv
module photon_sponge_hash
  import photon_pkg::*;
#(
  parameter int MSG_W = 128
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic [MSG_W-1:0]           msg_i,
  input  logic [$clog2(MSG_W+1)-1:0] len_i,
  output logic [DIGEST_W-1:0]        digest_o,
  output logic                       done_o
);
  localparam int LEN_W  = $clog2(MSG_W + 1);
  localparam int MAXBLK = MSG_W / RATE + 1;
  localparam int BLK_W  = $clog2(MAXBLK + 1);
  localparam int SQN_W  = $clog2(N_LANES);

  phase_t             ph;
  logic [STATE_W-1:0] st, st_nx;
  logic [RND_W-1:0]   rnd;
  logic [BLK_W-1:0]   blk, nblk;
  logic [SQN_W-1:0]   sqn;
  logic               sqz_ph;
  logic [MSG_W-1:0]   msg_q;
  logic [LEN_W-1:0]   len_q;
  logic [RATE-1:0]    pad_blk;
  logic               accept, last_rnd;

  assign accept   = start_i && (ph == PH_IDLE);
  assign last_rnd = (rnd == RND_W'(ROUNDS - 1));

  photon_pad #(.MSG_W(MSG_W), .LEN_W(LEN_W), .BLK_W(BLK_W)) u_pad (
    .msg_i(msg_q), .len_i(len_q), .blk_i(blk), .blk_o(pad_blk));

  photon_round u_round (.st_i(st), .rnd_i(rnd), .st_o(st_nx));

  photon_merge #(.LANE_W(SQZ_W), .N_LANES(N_LANES)) u_merge (
    .clk(clk), .rst(rst), .clr_i(accept), .shift_i(ph == PH_SQZ),
    .lane_i(st[STATE_W-1 -: SQZ_W]), .dout_o(digest_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      st     <= '0;
      rnd    <= '0;
      blk    <= '0;
      nblk   <= BLK_W'(1);
      sqn    <= '0;
      sqz_ph <= 1'b0;
      msg_q  <= '0;
      len_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (ph)
        PH_IDLE: if (start_i) begin
          msg_q  <= msg_i;
          len_q  <= len_i;
          nblk   <= BLK_W'(32'(len_i) / RATE + 1);
          blk    <= '0;
          sqn    <= '0;
          sqz_ph <= 1'b0;
          st     <= {{(STATE_W-TAIL_W){1'b0}}, IV_TAIL};
          ph     <= PH_ABSORB;
        end
        PH_ABSORB: begin
          st[STATE_W-1 -: RATE] <= st[STATE_W-1 -: RATE] ^ pad_blk;
          rnd <= '0;
          ph  <= PH_PERM;
        end
        PH_PERM: begin
          st  <= st_nx;
          rnd <= rnd + RND_W'(1);
          if (last_rnd) begin
            if (sqz_ph) begin
              ph <= PH_SQZ;
            end else if (blk == nblk - BLK_W'(1)) begin
              sqz_ph <= 1'b1;
              ph     <= PH_SQZ;
            end else begin
              blk <= blk + BLK_W'(1);
              ph  <= PH_ABSORB;
            end
          end
        end
        PH_SQZ: begin
          sqn <= sqn + SQN_W'(1);
          rnd <= '0;
          if (sqn == SQN_W'(N_LANES - 1)) begin
            done_o <= 1'b1;
            ph     <= PH_IDLE;
          end else begin
            ph <= PH_PERM;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IDLE && !start_i) |=> $stable(digest_o));
  // R5
  round_range_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_PERM) |-> (rnd < RND_W'(ROUNDS)));
  // R4
  block_range_chk: assert property (@(posedge clk) disable iff (rst)
    (ph != PH_IDLE) |-> (blk < nblk));
  // R9
  lane_count_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_SQZ) |-> (sqn < SQN_W'(N_LANES)));
  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (ph != PH_IDLE && start_i) |=> $stable(len_q));
endmodule

// File: tb/tb_photon_sponge_hash.sv
module tb_photon_sponge_hash;
  localparam int CLK_PERIOD = 10;
  localparam int MSG_W      = 128;
  localparam int LEN_W      = $clog2(MSG_W + 1);
  localparam int WATCHDOG   = 190000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [MSG_W-1:0]  msg = '0;
  logic [LEN_W-1:0]  len = '0;
  logic [79:0]       digest;
  logic              done;
  int                tests = 0;
  int                fails = 0;
  int                cycles = 0;
  bit                finished = 1'b0;
  logic [31:0]       seed = 32'h1234abcd;

  always #(CLK_PERIOD/2) clk = ~clk;

  photon_sponge_hash #(.MSG_W(MSG_W)) dut (
    .clk(clk), .rst(rst), .start_i(start), .msg_i(msg), .len_i(len),
    .digest_o(digest), .done_o(done));

  function automatic logic [3:0] m_sbox(input logic [3:0] x);
    logic [63:0] tbl;
    tbl = 64'hC56B90AD3EF84712;
    m_sbox = tbl[63-4*x -: 4];
  endfunction

  function automatic logic [3:0] m_gmul(input logic [3:0] a, input logic [3:0] b);
    logic [6:0] p;
    p = '0;
    for (int i = 0; i < 4; i++) if (b[i]) p = p ^ (7'(a) << i);
    for (int k = 6; k >= 4; k--) if (p[k]) p = p ^ (7'b0010011 << (k - 4));
    m_gmul = p[3:0];
  endfunction

  function automatic logic [99:0] m_perm(input logic [99:0] s);
    logic [3:0] a [25];
    logic [3:0] b [25];
    logic [3:0] rc, t, x0;
    logic [19:0] ic;
    ic = 20'h01364;
    rc = 4'd1;
    for (int k = 0; k < 25; k++) a[k] = s[99-4*k -: 4];
    for (int rd = 0; rd < 12; rd++) begin
      for (int r = 0; r < 5; r++) a[r*5] = a[r*5] ^ rc ^ ic[19-4*r -: 4];
      rc = {rc[2:0], ~(rc[3] ^ rc[2])};
      for (int k = 0; k < 25; k++) a[k] = m_sbox(a[k]);
      for (int r = 0; r < 5; r++)
        for (int c = 0; c < 5; c++) b[r*5+c] = a[r*5 + (c + r) % 5];
      for (int k = 0; k < 25; k++) a[k] = b[k];
      for (int c = 0; c < 5; c++)
        for (int it = 0; it < 5; it++) begin
          t = m_gmul(4'd1, a[c]) ^ m_gmul(4'd2, a[5+c]) ^ m_gmul(4'd9, a[10+c]) ^
              m_gmul(4'd9, a[15+c]) ^ m_gmul(4'd2, a[20+c]);
          x0 = t;
          for (int r = 0; r < 4; r++) a[r*5+c] = a[(r+1)*5+c];
          a[20+c] = x0;
        end
    end
    for (int k = 0; k < 25; k++) m_perm[99-4*k -: 4] = a[k];
  endfunction

  function automatic logic [79:0] m_hash(input logic [MSG_W-1:0] m, input int n);
    logic [99:0] s;
    logic [19:0] blk;
    logic [79:0] dg;
    int p;
    s  = 100'h141410;
    dg = '0;
    for (int b = 0; b < n / 20 + 1; b++) begin
      for (int j = 0; j < 20; j++) begin
        p = b * 20 + j;
        blk[19-j] = (p < n) ? m[MSG_W-1-p] : (p == n);
      end
      s[99:80] = s[99:80] ^ blk;
      s = m_perm(s);
    end
    for (int q = 0; q < 5; q++) begin
      if (q > 0) s = m_perm(s);
      dg = {dg[63:0], s[99:84]};
    end
    m_hash = dg;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic next_msg(output logic [MSG_W-1:0] m);
    for (int w = 0; w < MSG_W / 32; w++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      m[32*w +: 32] = seed;
    end
  endtask

  task automatic run_hash(input logic [MSG_W-1:0] m, input int n,
                          output logic [79:0] dg, output int cyc);
    @(negedge clk);
    msg = m; len = LEN_W'(n); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk); cyc++; #1;
    end
    dg = digest;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG && !finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [MSG_W-1:0] m1, m2;
    logic [79:0] dg, dg2, held;
    int cyc;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(done == 1'b0, "R1 done after reset", 80'(done), 80'(0));
    chk(digest == '0, "R1 digest after reset", digest, 80'(0));

    // R2 R3 R4 R5 R6 R7 R8 R9 R10: sweep every length
    for (int n = 0; n <= MSG_W; n++) begin
      next_msg(m1);
      run_hash(m1, n, dg, cyc);
      chk(dg == m_hash(m1, n), "R2 R3 R4 R5 R6 R7 R8 R9 digest", dg, m_hash(m1, n));
      chk(cyc == 13 * (n / 20 + 1) + 53, "R10 latency", 80'(cyc), 80'(13 * (n / 20 + 1) + 53));
      @(posedge clk); #1;
      chk(done == 1'b0, "R10 done width", 80'(done), 80'(0));
      if (n % 32 == 5) begin
        held = digest;
        repeat (6) @(posedge clk);
        #1;
        chk(digest == held, "R11 digest held after done", digest, held);
      end
    end

    // R2 bits beyond the length are ignored
    for (int t = 0; t < 4; t++) begin
      int n;
      n = (t == 0) ? 0 : (t == 1) ? 37 : (t == 2) ? 60 : 99;
      next_msg(m1);
      m2 = m1 & ~({MSG_W{1'b1}} >> n);
      run_hash(m1, n, dg, cyc);
      run_hash(m2, n, dg2, cyc);
      chk(dg == dg2, "R2 trailing bits ignored", dg, dg2);
      chk(dg2 == m_hash(m2, n), "R2 clean message digest", dg2, m_hash(m2, n));
    end

    // R11 start during a run is ignored
    next_msg(m1);
    @(negedge clk);
    msg = m1; len = LEN_W'(45); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk); cyc++; #1;
      if (cyc == 30) begin msg = ~m1; len = LEN_W'(5); start = 1'b1; end
      else start = 1'b0;
    end
    chk(digest == m_hash(m1, 45), "R11 busy start ignored digest", digest, m_hash(m1, 45));
    chk(cyc == 13 * 3 + 53, "R11 busy start latency", 80'(cyc), 80'(13 * 3 + 53));

    // R1 reset in the middle of a run
    next_msg(m1);
    @(negedge clk);
    msg = m1; len = LEN_W'(70); start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (80) @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    chk(done == 1'b0, "R1 done after mid-run reset", 80'(done), 80'(0));
    chk(digest == '0, "R1 digest after mid-run reset", digest, 80'(0));
    @(negedge clk) rst = 1'b0;
    run_hash(m1, 70, dg, cyc);
    chk(dg == m_hash(m1, 70), "R1 R9 digest after recovery", dg, m_hash(m1, 70));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule